// File: doc/BRIEF.md
# Even/Odd Byte-Lane Vector Multiplier

This execution unit accepts one 32-bit instruction word together with two 128-bit source vectors. It decodes a family of four byte-multiply operations and returns a 128-bit vector of eight 16-bit products. Each operation picks either the even-numbered or the odd-numbered bytes of both sources. Lanes are numbered big-endian, so byte 0 is the most significant byte. Each operation treats those bytes as signed or unsigned and multiplies them pairwise into full half-words. There is no saturation and no status output. The decoded destination register index travels with the result, so a register file downstream can do the write.

The unit is one registered pipeline stage with a valid/ready handshake on each side. A small controller with two states, EMPTY and FULL, governs it:
- **LOAD** (EMPTY to FULL) on an accepted input.
- **IDLE** (EMPTY to EMPTY) when no input is offered.
- **DRAIN** (FULL to EMPTY) when the result is taken and no new input is offered.
- **REFILL** (FULL to FULL) when the result is taken and a new input is accepted in the same cycle.
- **STALL** (FULL to FULL) while the consumer holds off.

An instruction that does not belong to the family still passes through the stage. Its result is all zeros and an illegal flag is set.

Top module: `vmul_unit`

## Requirements
- R1: Instruction bits are numbered MSB-first. The primary opcode is in_instr[31:26] and must equal 4. The destination index is in_instr[25:21] and appears on out_vd with the result. The extended opcode is in_instr[10:0]. The fields in_instr[20:16] and in_instr[15:11] do not affect the result.
- R2: Extended opcode 776 is signed-even. Byte k of a vector occupies bits [127-8k:120-8k]. Output half-word i (i = 0..7) occupies bits [127-16i:112-16i]. For this opcode it equals the low 16 bits of sext(A byte 2i) × sext(B byte 2i).
- R3: Extended opcode 264 is signed-odd. Output half-word i is sext(A byte 2i+1) × sext(B byte 2i+1).
- R4: Extended opcode 520 is unsigned-even. Output half-word i is zext(A byte 2i) × zext(B byte 2i).
- R5: Extended opcode 8 is unsigned-odd. Output half-word i is zext(A byte 2i+1) × zext(B byte 2i+1).
- R6: Products are exact and never clipped. Signed 0x80 × 0x80 gives 0x4000, signed 0x7F × 0x80 gives 0xC080, and unsigned 0xFF × 0xFF gives 0xFE01.
- R7: In these cases out_illegal is 1 and out_result is all zeros:
  - a primary opcode other than 4;
  - an extended opcode outside {8, 264, 520, 776}.
  For the four legal operations out_illegal is 0.
- R8: An input accepted at a clock edge (in_valid and in_ready both high) makes out_valid high after that edge, carrying its result.
- R9: While out_valid is 1 and out_ready is 0, out_result, out_vd and out_illegal hold their values, out_valid stays 1, and in_ready is 0.
- R10: in_ready is 1 whenever the stage is empty or out_ready is 1. A new input is accepted in the same cycle the held result is consumed, so back-to-back operations need no wait cycles.
- R11: A synchronous active-high reset empties the stage. After reset out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation offered |
| in_ready | output | 1 | Stage can accept an operation this cycle |
| in_instr | input | 32 | Instruction word |
| in_va | input | 128 | Source vector A |
| in_vb | input | 128 | Source vector B |
| out_valid | output | 1 | Result held in the stage |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 128 | Eight 16-bit products |
| out_vd | output | 5 | Destination register index |
| out_illegal | output | 1 | Instruction is not one of the four multiplies |

## Verification
Some properties are checked on every cycle:
- a stalled result stays stable;
- an accepted input always yields a full stage on the next cycle;
- a refill keeps the stage full;
- an illegal result is always zero;
- every signed product whose factors are both nonzero has the sign their signs predict.

Other properties only the bench scenarios can show. These are the actual lane values for each of the four opcodes, the choice of even against odd bytes, the products at the extremes of the number range, the opcodes that are rejected, the destination index carried through, and the one-cycle latency. The bench also shows the zero-wait back-to-back flow under a consumer that sometimes stalls, and the state after reset.

// File: rtl/vmul_pkg.sv
package vmul_pkg;

    localparam int INSTR_W   = 32;
    localparam int PRIM_W    = 6;
    localparam int REG_IDX_W = 5;
    localparam int XO_W      = 11;
    localparam int VEC_W     = 128;
    localparam int BYTE_W    = 8;

    localparam logic [PRIM_W-1:0] PRIM_VX   = 6'd4;
    localparam logic [XO_W-1:0]   XO_MUL_UO = 11'd8;
    localparam logic [XO_W-1:0]   XO_MUL_SO = 11'd264;
    localparam logic [XO_W-1:0]   XO_MUL_UE = 11'd520;
    localparam logic [XO_W-1:0]   XO_MUL_SE = 11'd776;

    typedef enum logic [1:0] {
        MUL_UO,
        MUL_SO,
        MUL_UE,
        MUL_SE
    } mul_kind_e;

    typedef struct packed {
        logic                 legal;
        logic                 even;
        logic                 signd;
        logic [REG_IDX_W-1:0] vd;
    } mul_dec_t;

    typedef enum logic {
        ST_EMPTY,
        ST_FULL
    } stage_st_e;

endpackage

// File: rtl/vmul_decode.sv
module vmul_decode
    import vmul_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int PW = PRIM_W,
    parameter int XW = XO_W
) (
    input  logic [IW-1:0] instr,
    output mul_dec_t      dec
);
    localparam int PRIM_HI = IW - 1;
    localparam int VD_HI   = IW - PW - 1;

    logic [PW-1:0] prim;
    logic [XW-1:0] xo;
    logic          xo_hit;
    mul_kind_e     kind;

    always_comb begin
        prim   = instr[PRIM_HI -: PW];
        xo     = instr[XW-1:0];
        xo_hit = 1'b1;
        kind   = MUL_UO;
        unique case (xo)
            XO_MUL_UO: kind = MUL_UO;
            XO_MUL_SO: kind = MUL_SO;
            XO_MUL_UE: kind = MUL_UE;
            XO_MUL_SE: kind = MUL_SE;
            default:   xo_hit = 1'b0;
        endcase
        dec.vd    = instr[VD_HI -: REG_IDX_W];
        dec.legal = (prim == PRIM_VX) && xo_hit;
        dec.even  = (kind == MUL_UE) || (kind == MUL_SE);
        dec.signd = (kind == MUL_SO) || (kind == MUL_SE);
    end

endmodule

// File: rtl/vmul_lane.sv
module vmul_lane #(
    parameter int BW = 8
) (
    input  logic [BW-1:0]   a,
    input  logic [BW-1:0]   b,
    input  logic            signd,
    output logic [2*BW-1:0] prod
);
    localparam int HW = 2 * BW;

    logic [HW-1:0] ext_a;
    logic [HW-1:0] ext_b;

    always_comb begin
        ext_a = {{BW{signd & a[BW-1]}}, a};
        ext_b = {{BW{signd & b[BW-1]}}, b};
        prod  = ext_a * ext_b;
    end

    // R2
    always_comb begin
        if (!$isunknown({a, b, signd}) && signd && (a != '0) && (b != '0)) begin
            prod_sign_chk: assert (prod[HW-1] == (a[BW-1] ^ b[BW-1]));
        end
    end

endmodule

// File: rtl/vmul_datapath.sv
module vmul_datapath
    import vmul_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int BW = BYTE_W
) (
    input  logic [VW-1:0] va,
    input  logic [VW-1:0] vb,
    input  mul_dec_t      dec,
    output logic [VW-1:0] result
);
    localparam int HW    = 2 * BW;
    localparam int LANES = VW / HW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int KE = 2 * i;
        localparam int KO = 2 * i + 1;
        logic [BW-1:0] sel_a;
        logic [BW-1:0] sel_b;
        logic [HW-1:0] prod;

        always_comb begin
            sel_a = dec.even ? va[VW-1-BW*KE -: BW] : va[VW-1-BW*KO -: BW];
            sel_b = dec.even ? vb[VW-1-BW*KE -: BW] : vb[VW-1-BW*KO -: BW];
        end

        vmul_lane #(.BW(BW)) u_lane (
            .a     (sel_a),
            .b     (sel_b),
            .signd (dec.signd),
            .prod  (prod)
        );

        assign result[VW-1-HW*i -: HW] = dec.legal ? prod : '0;
    end

endmodule

// File: rtl/vmul_stage.sv
module vmul_stage
    import vmul_pkg::*;
#(
    parameter int DW = 134
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    stage_st_e     state;
    stage_st_e     state_nxt;
    logic          load;
    logic [DW-1:0] data_q;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: state_nxt = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nxt = (out_ready && !in_valid) ? ST_EMPTY : ST_FULL;
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nxt;
    end

    always_comb begin
        in_ready  = (state == ST_EMPTY) || out_ready;
        out_valid = (state == ST_FULL);
        out_data  = data_q;
        load      = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (load) data_q <= in_data;
    end

    // R8
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10
    refill_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && in_valid) |=> out_valid);

endmodule

// File: rtl/vmul_unit.sv
module vmul_unit
    import vmul_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int VW = VEC_W,
    parameter int BW = BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [IW-1:0]        in_instr,
    input  logic [VW-1:0]        in_va,
    input  logic [VW-1:0]        in_vb,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [VW-1:0]        out_result,
    output logic [REG_IDX_W-1:0] out_vd,
    output logic                 out_illegal
);
    localparam int DW = VW + REG_IDX_W + 1;

    mul_dec_t      dec;
    logic [VW-1:0] result;
    logic [DW-1:0] stage_in;
    logic [DW-1:0] stage_out;

    vmul_decode #(.IW(IW)) u_decode (
        .instr (in_instr),
        .dec   (dec)
    );

    vmul_datapath #(.VW(VW), .BW(BW)) u_dp (
        .va     (in_va),
        .vb     (in_vb),
        .dec    (dec),
        .result (result)
    );

    assign stage_in = {~dec.legal, dec.vd, result};

    vmul_stage #(.DW(DW)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (stage_in),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (stage_out)
    );

    assign out_illegal = stage_out[DW-1];
    assign out_vd      = stage_out[VW +: REG_IDX_W];
    assign out_result  = stage_out[VW-1:0];

    // R7
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_result == '0));

endmodule

// File: tb/tb_vmul_unit.sv
`timescale 1ns/1ps
module tb_vmul_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  in_instr;
    logic [127:0] in_va;
    logic [127:0] in_vb;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_result;
    logic [4:0]   out_vd;
    logic         out_illegal;

    typedef struct {
        logic [127:0] res;
        logic [4:0]   vd;
        logic         ill;
        string        tag;
    } exp_t;

    exp_t   q[$];
    int     n_chk  = 0;
    int     n_fail = 0;
    int     mode   = 0;
    bit     done   = 0;

    always #2.5 clk = ~clk;

    vmul_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_va(in_va), .in_vb(in_vb),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
        .out_vd(out_vd), .out_illegal(out_illegal)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] ins, input logic [127:0] a,
                                   input logic [127:0] b, input string tag);
        exp_t e;
        logic [10:0] xo;
        bit ev, sg, ok;
        xo = ins[10:0];
        ok = (ins[31:26] == 6'd4) && (xo == 11'd8 || xo == 11'd264 || xo == 11'd520 || xo == 11'd776);
        ev = (xo == 11'd520) || (xo == 11'd776);
        sg = (xo == 11'd264) || (xo == 11'd776);
        e.res = '0;
        if (ok) begin
            for (int i = 0; i < 8; i++) begin
                int k;
                int x;
                int y;
                k = ev ? 2 * i : 2 * i + 1;
                x = int'(a[127-8*k -: 8]);
                y = int'(b[127-8*k -: 8]);
                if (sg && x > 127) x = x - 256;
                if (sg && y > 127) y = y - 256;
                e.res[127-16*i -: 16] = 16'(x * y);
            end
        end
        e.vd  = ins[25:21];
        e.ill = !ok;
        e.tag = tag;
        return e;
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] p, input logic [4:0] vd,
                                       input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [10:0] xo);
        return {p, vd, ra, rb, xo};
    endfunction

    task automatic drive(input logic [31:0] ins, input logic [127:0] a,
                         input logic [127:0] b, input string tag, output int waits);
        bit ok;
        waits = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = ins;
        in_va    = a;
        in_vb    = b;
        forever begin
            #1 ok = in_ready;
            @(posedge clk);
            if (ok) break;
            waits++;
            @(negedge clk);
        end
        q.push_back(model(ins, a, b, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (q.size() != 0 && t < 1000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    // consumer ready pattern
    initial begin
        int lfsr;
        lfsr = 32'h1;
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (mode)
                1:       out_ready = lfsr[3] | lfsr[7];
                2:       out_ready = 1'b0;
                default: out_ready = 1'b1;
            endcase
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && out_valid && out_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected result", out_result, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(out_result == e.res, e.tag, "result", out_result, e.res);
                    chk(out_vd == e.vd, "R1", "dest index", 128'(out_vd), 128'(e.vd));
                    chk(out_illegal == e.ill, "R7", "illegal flag", 128'(out_illegal), 128'(e.ill));
                end
            end
        end
    end

    // watchdog
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            chk(1'b0, "R8", "watchdog expired", '0, '0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int w;
        logic [127:0] held;
        logic [10:0] xos[4];
        string tags[4];
        xos[0] = 11'd776; tags[0] = "R2";
        xos[1] = 11'd264; tags[1] = "R3";
        xos[2] = 11'd520; tags[2] = "R4";
        xos[3] = 11'd8;   tags[3] = "R5";

        rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_va = '0; in_vb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11
        chk(out_valid == 1'b0, "R11", "out_valid after reset", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R11", "in_ready after reset", 128'(in_ready), 128'(1));

        // R6 extremes, R2 exact opcode word
        drive(32'h10000308, {16{8'h80}}, {16{8'h80}}, "R6", w);
        drive(mk(6'd4, 5'd3, 5'd0, 5'd0, 11'd776), {16{8'h7F}}, {16{8'h80}}, "R6", w);
        drive(mk(6'd4, 5'd4, 5'd0, 5'd0, 11'd520), {16{8'hFF}}, {16{8'hFF}}, "R6", w);
        drive(mk(6'd4, 5'd5, 5'd0, 5'd0, 11'd8), {16{8'hFF}}, {16{8'hFF}}, "R6", w);
        // even/odd separation: even bytes 0x02, odd bytes 0x81
        drive(mk(6'd4, 5'd6, 5'd0, 5'd0, 11'd776), {8{16'h0281}}, {8{16'h0381}}, "R2", w);
        drive(mk(6'd4, 5'd7, 5'd0, 5'd0, 11'd264), {8{16'h0281}}, {8{16'h0381}}, "R3", w);
        // R1 register fields A/B do not affect the result
        drive(mk(6'd4, 5'd31, 5'd17, 5'd9, 11'd264), {8{16'h0281}}, {8{16'h0381}}, "R1", w);
        // R7 illegal encodings
        drive(mk(6'd5, 5'd1, 5'd0, 5'd0, 11'd776), {16{8'h11}}, {16{8'h22}}, "R7", w);
        drive(mk(6'd4, 5'd2, 5'd0, 5'd0, 11'd777), {16{8'h11}}, {16{8'h22}}, "R7", w);
        drive(mk(6'd4, 5'd3, 5'd0, 5'd0, 11'd0), {16{8'h11}}, {16{8'h22}}, "R7", w);
        drive(mk(6'd0, 5'd4, 5'd0, 5'd0, 11'd8), {16{8'h11}}, {16{8'h22}}, "R7", w);
        idle();
        drain();

        // R10 back-to-back with consumer always ready
        for (int n = 0; n < 8; n++) begin
            drive(mk(6'd4, 5'(n), 5'd0, 5'd0, xos[n % 4]),
                  {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom}, tags[n % 4], w);
            chk(w == 0, "R10", "wait cycles in back-to-back flow", 128'(w), 128'(0));
        end
        idle();
        drain();

        // random streams under random back-pressure
        mode = 1;
        for (int n = 0; n < 80; n++) begin
            drive(mk(6'd4, 5'($urandom), 5'($urandom), 5'($urandom), xos[n % 4]),
                  {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom}, tags[n % 4], w);
        end
        idle();
        mode = 0;
        drain();

        // R8 / R9 / R10 stall sequence
        mode = 2;
        @(negedge clk);
        @(negedge clk);
        drive(mk(6'd4, 5'd9, 5'd0, 5'd0, 11'd520), {16{8'hC3}}, {16{8'h5A}}, "R9", w);
        idle();
        #1;
        chk(out_valid == 1'b1, "R8", "out_valid one cycle after accept", 128'(out_valid), 128'(1));
        chk(in_ready == 1'b0, "R9", "in_ready while stalled", 128'(in_ready), 128'(0));
        held = out_result;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            #1;
            chk(out_valid == 1'b1, "R9", "out_valid held", 128'(out_valid), 128'(1));
            chk(out_result == held, "R9", "result held", out_result, held);
            chk(out_vd == 5'd9, "R9", "dest held", 128'(out_vd), 128'(9));
        end
        mode = 0;
        @(negedge clk);
        #1;
        chk(out_valid && in_ready, "R10", "in_ready while full and consumer ready",
            128'(in_ready), 128'(1));
        drain();

        // R11 reset mid-operation
        mode = 2;
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = 32'h10000308;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R11", "reset empties stage", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R11", "in_ready after mid reset", 128'(in_ready), 128'(1));
        mode = 0;
        repeat (3) @(negedge clk);

        chk(q.size() == 0, "R8", "scoreboard empty at end", 128'(q.size()), 128'(0));
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule